// File: doc/BRIEF.md
# Lamp Ballast Supervisory Controller

This block sequences a fluorescent lamp ballast through its operating phases. It takes already-digitized comparator decisions about the supply and the lamp, and it moves between five phases: reset, start-up, ignition, burn and a latched power-down. Its outputs tell the half-bridge oscillator when to run, tell the frequency control whether the lamp is igniting or burning, enable the average-current loop while burning, and ask the supply clamp to engage while powered down.

Ignition is bounded by a one-shot window. The window opens the first time the lamp voltage is seen above the fail level during ignition. If the lamp voltage is still above that level when the window closes, the ballast has failed to strike. The controller then stops the bridge and stays down until the supply collapses below a dedicated reset level. If the lamp fails while burning, the controller goes back to ignition and gets a fresh window.

The lamp-fail comparator is asynchronous to the controller clock and passes through a flip-flop synchronizer. The supply comparators and the minimum-frequency flag are taken as synchronous inputs. The window length is a clock-cycle count chosen by parameter.

Top module: `lamp_supervisor`

## Requirements
- R1: While `rstN` is low the state code is 0 (reset) and `oscRun`, `burnMode`, `loopEnable` and `clampRequest` are all 0. On the first clock edge after release the state code becomes 1 (start-up).
- R2: In start-up (code 1) `oscRun` stays 0 for as long as `supplyAboveStart` is 0. On the edge where `supplyAboveStart` is 1 the state code becomes 2 (ignition), with `oscRun`=1 and `burnMode`=0.
- R3: In ignition or burn, `supplyBelowStop`=1 at a clock edge returns the controller to start-up (code 1, `oscRun`=0). This takes priority over every other condition in those phases.
- R4: `lampOverFail` passes through a two-stage synchronizer. A change applied between edges is seen by the state logic at the third following edge, and not earlier.
- R5: The ignition window opens at the first edge in ignition where the synchronized lamp-fail level is 1. It then runs for exactly `IGN_WINDOW_CYCLES` cycles, whatever the lamp input does in the meantime.
- R6: In ignition, `minFreqReached`=1 at an edge (with no stop or expiry condition) moves the controller to burn: code 3, `oscRun`=1, `burnMode`=1, `loopEnable`=1.
- R7: If the synchronized lamp-fail level is 1 on the edge where the window expires, the controller enters power-down: code 4, `oscRun`=0, `clampRequest`=1. Expiry with lamp fail takes priority over `minFreqReached`.
- R8: If the window expires while the synchronized lamp-fail level is 0, the controller stays in ignition. The window does not open again until ignition is left and re-entered.
- R9: In burn, a synchronized lamp-fail level of 1 at an edge returns the controller to ignition (code 2, `loopEnable`=0).
- R10: Power-down is latched. `supplyAboveStart` and `supplyBelowStop` have no effect there. Only `supplyBelowReset`=1 leaves it, going to reset (code 0) and then start-up.
- R11: The window timer is cleared whenever the controller is outside ignition. Each re-entry into ignition therefore gets a full `IGN_WINDOW_CYCLES` window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| supplyAboveStart | input | 1 | Supply above the start threshold |
| supplyBelowStop | input | 1 | Supply below the stop threshold |
| supplyBelowReset | input | 1 | Supply below the power-down release level |
| lampOverFail | input | 1 | Lamp voltage above fail level (asynchronous) |
| minFreqReached | input | 1 | Oscillator has reached its minimum frequency |
| oscRun | output | 1 | Half-bridge oscillator enable |
| burnMode | output | 1 | 1 = burn, 0 = ignition (meaningful while oscRun) |
| loopEnable | output | 1 | Average-current regulation loop enable |
| clampRequest | output | 1 | Supply clamp request (power-down) |
| stateCode | output | 3 | 0 reset, 1 start-up, 2 ignition, 3 burn, 4 power-down |

## Verification
The bench builds the controller with `IGN_WINDOW_CYCLES` set to 40 instead of the production count. This makes window expiry, the one-shot behaviour after an expiry with a healthy lamp, and a full fresh window after a burn-to-ignition return reachable within a few hundred cycles. `SYNC_STAGES` keeps its default of 2, so the three-edge lamp-fail latency is checked as it would be built.

// File: rtl/lamp_sup_pkg.sv
package lamp_sup_pkg;

  typedef enum logic [2:0] {
    PH_RESET   = 3'd0,
    PH_STARTUP = 3'd1,
    PH_IGNITE  = 3'd2,
    PH_BURN    = 3'd3,
    PH_PWRDN   = 3'd4
  } phase_t;

  // control -> datapath
  typedef struct packed {
    logic timerArm;    // window may open
    logic timerClear;  // hold timer at zero
  } ctrlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic lampFail;     // synchronized lamp-fail level
    logic windowDone;   // window expires at this edge
  } dpFlags_t;

endpackage

// File: rtl/lamp_sup_dp.sv
module lamp_sup_dp
  import lamp_sup_pkg::*;
#(
  parameter int IGN_WINDOW_CYCLES = 25_700_000,
  parameter int SYNC_STAGES       = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        lampOverFailAsync,
  input  ctrlStrobe_t strobe,
  output dpFlags_t    flags
);

  localparam int CNT_W = $clog2(IGN_WINDOW_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_COUNT = CNT_W'(IGN_WINDOW_CYCLES - 1);

  // ---------------- lamp-fail synchronizer ----------------
  logic [SYNC_STAGES-1:0] syncChain;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[0] <= 1'b0;
          else       syncChain[0] <= lampOverFailAsync;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[g] <= 1'b0;
          else       syncChain[g] <= syncChain[g-1];
        end
      end
    end
  endgenerate

  logic lampFailSync;
  assign lampFailSync = syncChain[SYNC_STAGES-1];

  // ---------------- one-shot ignition window ----------------
  logic             winRunning;
  logic             winSpent;
  logic [CNT_W-1:0] winCount;
  logic             winExpire;

  assign winExpire = winRunning && (winCount == LAST_COUNT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winRunning <= 1'b0;
      winSpent   <= 1'b0;
      winCount   <= '0;
    end else if (strobe.timerClear) begin
      winRunning <= 1'b0;
      winSpent   <= 1'b0;
      winCount   <= '0;
    end else if (winRunning) begin
      if (winExpire) begin
        winRunning <= 1'b0;
        winSpent   <= 1'b1;
      end else begin
        winCount <= winCount + 1'b1;
      end
    end else if (strobe.timerArm && lampFailSync && !winSpent) begin
      winRunning <= 1'b1;
      winCount   <= '0;
    end
  end

  assign flags.lampFail   = lampFailSync;
  assign flags.windowDone = winExpire;

  // ---------------- assertions ----------------
  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    winRunning |-> (winCount <= LAST_COUNT));

  p_cleared_outside_r11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.timerClear |=> (!winRunning && !winSpent && winCount == '0));

  p_one_shot_r8: assert property (@(posedge clk) disable iff (!rstN)
    (winSpent && !strobe.timerClear) |=> !winRunning);

  p_expire_ends_r5: assert property (@(posedge clk) disable iff (!rstN)
    (winExpire && !strobe.timerClear) |=> (winSpent && !winRunning));

endmodule

// File: rtl/lamp_sup_ctrl.sv
module lamp_sup_ctrl
  import lamp_sup_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        supplyAboveStart,
  input  logic        supplyBelowStop,
  input  logic        supplyBelowReset,
  input  logic        minFreqReached,
  input  dpFlags_t    flags,
  output ctrlStrobe_t strobe,
  output phase_t      phase
);

  phase_t phaseNext;

  always_comb begin
    phaseNext = phase;
    case (phase)
      PH_RESET:   phaseNext = PH_STARTUP;
      PH_STARTUP: if (supplyAboveStart) phaseNext = PH_IGNITE;
      PH_IGNITE: begin
        if (supplyBelowStop)                          phaseNext = PH_STARTUP;
        else if (flags.windowDone && flags.lampFail)  phaseNext = PH_PWRDN;
        else if (minFreqReached)                      phaseNext = PH_BURN;
      end
      PH_BURN: begin
        if (supplyBelowStop)     phaseNext = PH_STARTUP;
        else if (flags.lampFail) phaseNext = PH_IGNITE;
      end
      PH_PWRDN:   if (supplyBelowReset) phaseNext = PH_RESET;
      default:    phaseNext = PH_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_RESET;
    else       phase <= phaseNext;
  end

  assign strobe.timerArm   = (phase == PH_IGNITE);
  assign strobe.timerClear = (phase != PH_IGNITE);

  // ---------------- assertions ----------------
  p_hold_startup_r2: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_STARTUP && !supplyAboveStart) |=> phase == PH_STARTUP);

  p_stop_wins_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((phase == PH_IGNITE || phase == PH_BURN) && supplyBelowStop) |=> phase == PH_STARTUP);

  p_burn_refire_r9: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_BURN && !supplyBelowStop && flags.lampFail) |=> phase == PH_IGNITE);

  p_pwrdn_latch_r10: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_PWRDN && !supplyBelowReset) |=> phase == PH_PWRDN);

  p_pwrdn_entry_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(phase == PH_PWRDN) |-> $past(phase == PH_IGNITE && flags.windowDone));

endmodule

// File: rtl/lamp_supervisor.sv
module lamp_supervisor
  import lamp_sup_pkg::*;
#(
  parameter int IGN_WINDOW_CYCLES = 25_700_000,
  parameter int SYNC_STAGES       = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyAboveStart,
  input  logic       supplyBelowStop,
  input  logic       supplyBelowReset,
  input  logic       lampOverFail,
  input  logic       minFreqReached,
  output logic       oscRun,
  output logic       burnMode,
  output logic       loopEnable,
  output logic       clampRequest,
  output logic [2:0] stateCode
);

  ctrlStrobe_t strobe;
  dpFlags_t    flags;
  phase_t      phase;

  lamp_sup_ctrl i_ctrl (
    .clk              (clk),
    .rstN             (rstN),
    .supplyAboveStart (supplyAboveStart),
    .supplyBelowStop  (supplyBelowStop),
    .supplyBelowReset (supplyBelowReset),
    .minFreqReached   (minFreqReached),
    .flags            (flags),
    .strobe           (strobe),
    .phase            (phase)
  );

  lamp_sup_dp #(
    .IGN_WINDOW_CYCLES (IGN_WINDOW_CYCLES),
    .SYNC_STAGES       (SYNC_STAGES)
  ) i_dp (
    .clk               (clk),
    .rstN              (rstN),
    .lampOverFailAsync (lampOverFail),
    .strobe            (strobe),
    .flags             (flags)
  );

  assign oscRun       = (phase == PH_IGNITE) || (phase == PH_BURN);
  assign burnMode     = (phase == PH_BURN);
  assign loopEnable   = (phase == PH_BURN);
  assign clampRequest = (phase == PH_PWRDN);
  assign stateCode    = phase;

  p_bridge_off_clamp_r7: assert property (@(posedge clk) disable iff (!rstN)
    clampRequest |-> (!oscRun && !loopEnable));

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |-> (stateCode == 3'd0 && !oscRun && !clampRequest));

endmodule

// File: tb/test_lamp_supervisor.sv
module test_lamp_supervisor;

  localparam int W = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic aboveStart = 1'b0, belowStop = 1'b0, belowReset = 1'b0;
  logic lamp = 1'b0, minFreq = 1'b0;
  logic oscRun, burnMode, loopEnable, clampRequest;
  logic [2:0] stateCode;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  lamp_supervisor #(.IGN_WINDOW_CYCLES(W), .SYNC_STAGES(2)) i_lamp_supervisor (
    .clk(clk), .rstN(rstN),
    .supplyAboveStart(aboveStart), .supplyBelowStop(belowStop),
    .supplyBelowReset(belowReset), .lampOverFail(lamp),
    .minFreqReached(minFreq),
    .oscRun(oscRun), .burnMode(burnMode), .loopEnable(loopEnable),
    .clampRequest(clampRequest), .stateCode(stateCode)
  );

  // ---------------- behavioural reference model ----------------
  int mState = 0;
  int sA = 0, sB = 0;          // lamp synchronizer stages
  int tRun = 0, tCnt = 0, tSpent = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 0; sA = 0; sB = 0; tRun = 0; tCnt = 0; tSpent = 0;
    end else begin
      int lf, ex, nxt;
      lf  = sB;
      ex  = (tRun != 0 && tCnt == W - 1) ? 1 : 0;
      nxt = mState;
      if (mState == 0) nxt = 1;
      else if (mState == 1) begin if (aboveStart) nxt = 2; end
      else if (mState == 2) begin
        if (belowStop) nxt = 1;
        else if (ex && lf) nxt = 4;
        else if (minFreq) nxt = 3;
      end else if (mState == 3) begin
        if (belowStop) nxt = 1;
        else if (lf) nxt = 2;
      end else if (mState == 4) begin
        if (belowReset) nxt = 0;
      end
      if (mState != 2) begin tRun = 0; tCnt = 0; tSpent = 0; end
      else if (tRun != 0) begin
        if (ex) begin tRun = 0; tSpent = 1; end else tCnt++;
      end else if (lf && !tSpent) begin tRun = 1; tCnt = 0; end
      sB = sA; sA = lamp ? 1 : 0;
      mState = nxt;
    end
  end

  function automatic string tagOf(int s);
    case (s)
      0: return "R1";
      1: return "R2";
      2: return "R5";
      3: return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic compareModel();
    int expOut, actOut;
    expOut = {mState[2:0], (mState == 2 || mState == 3) ? 1'b1 : 1'b0,
              (mState == 3) ? 1'b1 : 1'b0, (mState == 3) ? 1'b1 : 1'b0,
              (mState == 4) ? 1'b1 : 1'b0};
    actOut = {stateCode, oscRun, burnMode, loopEnable, clampRequest};
    check(actOut == expOut, tagOf(mState), actOut, expOut);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compareModel();
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 20000);
      finishRun();
    end
  end

  initial begin
    // R1: reset state
    step(3);
    check(stateCode == 3'd0, "R1", stateCode, 0);
    check({oscRun, burnMode, loopEnable, clampRequest} == 4'b0, "R1",
          {oscRun, burnMode, loopEnable, clampRequest}, 0);
    rstN = 1'b1;
    step(1);
    check(stateCode == 3'd1, "R1", stateCode, 1);

    // R2: start-up holds until supply is above start
    step(4);
    check(stateCode == 3'd1 && !oscRun, "R2", stateCode, 1);
    aboveStart = 1'b1;
    step(1);
    check(stateCode == 3'd2 && oscRun && !burnMode, "R2", stateCode, 2);
    aboveStart = 1'b0;

    // normal strike: lamp spike then min frequency -> burn (R6)
    lamp = 1'b1; step(3);
    lamp = 1'b0; step(3);
    check(stateCode == 3'd2, "R5", stateCode, 2);
    minFreq = 1'b1; step(1);
    check(stateCode == 3'd3 && loopEnable && burnMode && oscRun, "R6", stateCode, 3);
    minFreq = 1'b0; step(2);

    // R4 latency, R9 burn -> ignition
    lamp = 1'b1; step(2);
    check(stateCode == 3'd3, "R4", stateCode, 3);
    step(1);
    check(stateCode == 3'd2 && !loopEnable, "R9", stateCode, 2);

    // R7: window expires with lamp still failed
    step(W);
    check(stateCode == 3'd2, "R7", stateCode, 2);
    step(1);
    check(stateCode == 3'd4 && !oscRun && clampRequest, "R7", stateCode, 4);
    lamp = 1'b0;

    // R10: latched power-down
    aboveStart = 1'b1; belowStop = 1'b1; step(5);
    check(stateCode == 3'd4 && clampRequest, "R10", stateCode, 4);
    aboveStart = 1'b0; belowStop = 1'b0; belowReset = 1'b1; step(1);
    check(stateCode == 3'd0, "R10", stateCode, 0);
    belowReset = 1'b0; step(1);
    check(stateCode == 3'd1, "R10", stateCode, 1);

    // R3: stop threshold from ignition and from burn
    aboveStart = 1'b1; step(1);
    aboveStart = 1'b0; belowStop = 1'b1; step(1);
    check(stateCode == 3'd1 && !oscRun, "R3", stateCode, 1);
    belowStop = 1'b0; aboveStart = 1'b1; step(1);
    aboveStart = 1'b0; minFreq = 1'b1; step(1);
    check(stateCode == 3'd3, "R6", stateCode, 3);
    minFreq = 1'b0; belowStop = 1'b1; lamp = 1'b1; step(1);
    check(stateCode == 3'd1 && !loopEnable, "R3", stateCode, 1);
    belowStop = 1'b0; lamp = 1'b0; step(3);

    // R8: expiry with healthy lamp leaves ignition running, no re-arm
    aboveStart = 1'b1; step(1);
    aboveStart = 1'b0;
    lamp = 1'b1; step(2);
    lamp = 1'b0; step(W + 10);
    check(stateCode == 3'd2 && oscRun, "R8", stateCode, 2);
    lamp = 1'b1; step(2 * W);
    check(stateCode == 3'd2, "R8", stateCode, 2);

    // R11: after burn, re-ignition gets a full fresh window
    lamp = 1'b0; step(3);
    minFreq = 1'b1; step(1);
    minFreq = 1'b0;
    check(stateCode == 3'd3, "R6", stateCode, 3);
    lamp = 1'b1; step(3);
    check(stateCode == 3'd2, "R9", stateCode, 2);
    step(W - 2);
    check(stateCode == 3'd2, "R11", stateCode, 2);
    step(5);
    check(stateCode == 3'd4 && clampRequest, "R11", stateCode, 4);

    lamp = 1'b0; belowReset = 1'b1; step(2);
    belowReset = 1'b0; step(2);
    check(stateCode == 3'd1, "R10", stateCode, 1);

    finishRun();
  end

endmodule